// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a small group of general-purpose input pins and raises an interrupt when any of them changes level. Each pin is first passed through a two-flop synchronizer. Any rising or falling edge of the synchronized level sets a sticky change flag for that pin. A host can read one register that holds both the sticky flags and the live synchronized levels. Reading that register clears the flags.

The flags are gated by per-pin enable bits and ORed into one summary bit. That summary bit is the top bit of an eight-source interrupt status word. The other seven bits come straight from neighbouring per-channel logic: break change, receive ready and transmit ready for two channels, plus a counter-ready flag. A mask register selects which of the eight sources may drive the shared active-low interrupt line.

The host port is a simple strobed interface with a two-bit address. Reads are combinational. Writes take effect at the next clock edge.

Top module: `pcirq_top`

## Requirements
- R1: Address 0 reads the change word. Bits 7:4 are the sticky change flags of pins 3..0 and bits 3:0 are the synchronized levels of pins 3..0. A new pin level shows in bits 3:0 after two rising clock edges.
- R2: Both a rising and a falling edge of a synchronized pin set that pin's change flag. The flag is visible three rising edges after the pin changes. Without a clear, the flag holds.
- R3: A read strobe (`rd_en`=1) at address 0 clears every change flag at that clock edge. If an edge arrives at the same edge as the clear, that pin's flag is set, not cleared.
- R4: After reset is released, pins already held high or low set no change flag.
- R5: Address 1 is the pin enable register. Bits 3:0 enable pins 3..0, bits 7:4 read as zero, and the register resets to zero.
- R6: Address 2 reads the status word. Bit 7 is the OR over pins of (change flag AND enable). Bits 6:0 follow `src_in[6:0]`, in the order: bit 6 break change B, bit 5 receive ready B, bit 4 transmit ready B, bit 3 counter ready, bit 2 break change A, bit 1 receive ready A, bit 0 transmit ready A.
- R7: Address 3 is the eight-bit mask, with bit positions matching the status word. A 1 enables that source. The mask resets to zero and reads back what was written.
- R8: `irq_n` is driven low one rising edge after (status AND mask) becomes nonzero. It returns high one edge after that value becomes zero. It is high in reset.
- R9: Writes to address 0 or address 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous input pins |
| src_in | input | 7 | Level flags of the other seven interrupt sources |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe (clears change flags at address 0) |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each result has a fixed latency, counted in rising edges:

| Result | Due after |
|---|---|
| Pin level in the change word | 2 edges after a pin change |
| Change flag | 3 edges after a pin change |
| `irq_n` from a pin | 4 edges after a pin change |
| `irq_n` from a source input or mask write | 1 edge after the change |
| Register reads | Same cycle (combinational) |

The bench drives every input on a falling edge and counts the rising edges to each due point. It samples at the falling edge where the result is due. In chosen cases it also samples one edge earlier, to show that the result is not there too soon. One read is placed on the exact edge where a flag is being set, to check that the set wins over the clear.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  localparam int PIN_CNT = 4;
  localparam int SRC_CNT = 7;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_CHANGE = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 2'd3;

  // Any source both flagged and unmasked.
  function automatic logic any_pending(input logic [REG_W-1:0] st,
                                       input logic [REG_W-1:0] mk);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < REG_W; b++) hit = hit | (st[b] & mk[b]);
    return hit;
  endfunction

  // Sticky flags above live levels.
  function automatic logic [REG_W-1:0] change_word(input logic [PIN_CNT-1:0] flg,
                                                   input logic [PIN_CNT-1:0] lvl);
    return {flg, lvl};
  endfunction

  // Summary bit: flags gated by per-pin enables.
  function automatic logic gated_any(input logic [PIN_CNT-1:0] flg,
                                     input logic [PIN_CNT-1:0] en);
    return |(flg & en);
  endfunction

endpackage

// File: rtl/pcirq_pin_sync.sv
module pcirq_pin_sync #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] edge_evt,
  output logic                armed
);

  localparam int ARM_LAST = SYNC_STAGES + 1;
  localparam int ARM_W    = $clog2(ARM_LAST + 1);

  logic [ARM_W-1:0]    arm_cnt;
  logic [NUM_PINS-1:0] prev_q;

  // Edge detection stays off until the synchronizer and the history flop
  // hold post-reset pin values.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_cnt <= '0;
    else if (arm_cnt != ARM_W'(ARM_LAST)) arm_cnt <= arm_cnt + 1'b1;
  end
  assign armed = (arm_cnt == ARM_W'(ARM_LAST));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain     <= '0;
        prev_q[i] <= 1'b0;
      end else begin
        chain     <= {chain[SYNC_STAGES-2:0], pin_in[i]};
        prev_q[i] <= chain[SYNC_STAGES-1];
      end
    end
    assign level[i]    = chain[SYNC_STAGES-1];
    assign edge_evt[i] = armed & (level[i] ^ prev_q[i]);

    // R2: an event is a real change of the synchronized level
    a_r2_evt_is_change: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |-> level[i] != $past(level[i]));
  end

  // R4: once armed, the detector stays armed until reset
  a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

endmodule

// File: rtl/pcirq_delta_bank.sv
module pcirq_delta_bank #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] edge_evt,
  input  logic                clr_strobe,
  input  logic                en_wr,
  input  logic [NUM_PINS-1:0] en_wdata,
  output logic [NUM_PINS-1:0] delta_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic                summary
);
  import pcirq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           delta_q[i] <= 1'b0;
      else if (edge_evt[i]) delta_q[i] <= 1'b1;  // set beats clear
      else if (clr_strobe)  delta_q[i] <= 1'b0;
    end

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |=> delta_q[i]);
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_strobe && !edge_evt[i] |=> !delta_q[i]);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_strobe && !edge_evt[i] |=> $stable(delta_q[i]));
  end

  assign summary = gated_any(delta_q, en_q);

  a_r5_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_q == $past(en_wdata));

endmodule

// File: rtl/pcirq_irq_core.sv
module pcirq_irq_core #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               summary,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               mask_wr,
  input  logic [NUM_SRC:0]   mask_wdata,
  output logic [NUM_SRC:0]   status,
  output logic [NUM_SRC:0]   mask_q,
  output logic               irq_n
);
  import pcirq_pkg::*;

  logic pending;

  assign status  = {summary, src_in};
  assign pending = any_pending(status, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~pending;
  end

  a_r8_assert: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !irq_n);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> irq_n);
  a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(mask_wdata));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/pcirq_top.sv
module pcirq_top #(
  parameter int NUM_PINS    = pcirq_pkg::PIN_CNT,
  parameter int NUM_SRC     = pcirq_pkg::SRC_CNT,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          pin_in,
  input  logic [NUM_SRC-1:0]           src_in,
  input  logic                         wr_en,
  input  logic [pcirq_pkg::ADDR_W-1:0] wr_addr,
  input  logic [pcirq_pkg::REG_W-1:0]  wr_data,
  input  logic                         rd_en,
  input  logic [pcirq_pkg::ADDR_W-1:0] rd_addr,
  output logic [pcirq_pkg::REG_W-1:0]  rd_data,
  output logic                         irq_n
);
  import pcirq_pkg::*;

  localparam int PAD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] level, edge_evt, delta_q, en_q;
  logic                armed, summary, clr_strobe, en_wr, mask_wr;
  logic [NUM_SRC:0]    status, mask_q;

  assign clr_strobe = rd_en && (rd_addr == ADR_CHANGE);
  assign en_wr      = wr_en && (wr_addr == ADR_ENABLE);
  assign mask_wr    = wr_en && (wr_addr == ADR_MASK);

  pcirq_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .level(level), .edge_evt(edge_evt), .armed(armed)
  );

  pcirq_delta_bank #(.NUM_PINS(NUM_PINS)) u_delta (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .clr_strobe(clr_strobe),
    .en_wr(en_wr), .en_wdata(wr_data[NUM_PINS-1:0]),
    .delta_q(delta_q), .en_q(en_q), .summary(summary)
  );

  pcirq_irq_core #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .summary(summary), .src_in(src_in),
    .mask_wr(mask_wr), .mask_wdata(wr_data), .status(status),
    .mask_q(mask_q), .irq_n(irq_n)
  );

  always_comb begin
    case (rd_addr)
      ADR_CHANGE: rd_data = change_word(delta_q, level);
      ADR_ENABLE: rd_data = {{PAD_W{1'b0}}, en_q};
      ADR_STATUS: rd_data = status;
      default:    rd_data = mask_q;
    endcase
  end

  // R5: upper enable bits always read zero
  a_r5_en_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == ADR_ENABLE |-> rd_data[REG_W-1:NUM_PINS] == '0);
  // R4: no change flag during the arming window after reset
  a_r4_no_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> delta_q == '0);

endmodule

// File: tb/pcirq_top_bench.sv
`timescale 1ns/1ps
module pcirq_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_in = '0;
  logic [6:0] src_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcirq_top u_pcirq_top (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_in(src_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  // {mask[7:0], src[6:0], expected irq_n}
  localparam logic [15:0] VEC [8] = '{
    16'h00FF, 16'h0102, 16'h01FD, 16'h4080,
    16'h3C87, 16'h3C10, 16'hFF01, 16'h80FF
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(2);
    rst_n = 1'b1;
    tick(6);

    // Reset state
    chk("R8 reset irq_n", {7'd0, irq_n}, 8'h01);
    rd(2'd0, v); chk("R1 reset change", v, 8'h00);
    rd(2'd1, v); chk("R5 reset enable", v, 8'h00);
    rd(2'd3, v); chk("R7 reset mask", v, 8'h00);
    rd(2'd2, v); chk("R6 reset status", v, 8'h00);

    // Rising edge on pin 1: level after 2 edges; read clears at edge 3 where flag sets
    pin_in[1] = 1'b1;
    tick(2);
    rd(2'd0, v); chk("R1 level after two edges", v, 8'h02);
    rd(2'd0, v); chk("R3 set wins over clear", v, 8'h22);
    rd(2'd0, v); chk("R3 read cleared flag", v, 8'h02);

    // Falling edge also flags
    pin_in[1] = 1'b0;
    tick(3);
    rd(2'd0, v); chk("R2 falling edge flag", v, 8'h20);
    rd(2'd0, v); chk("R2 cleared after fall", v, 8'h00);

    // Enabled pin 2 drives irq through mask bit 7
    wr(2'd1, 8'h04);
    wr(2'd3, 8'h80);
    pin_in[2] = 1'b1;
    tick(3);
    chk("R8 irq not before due edge", {7'd0, irq_n}, 8'h01);
    tick(1);
    chk("R8 irq from pin", {7'd0, irq_n}, 8'h00);
    rd(2'd2, v); chk("R6 summary bit set", v, 8'h80);
    rd(2'd0, v); chk("R1 flag and level pin2", v, 8'h44);
    chk("R8 irq held one edge after clear", {7'd0, irq_n}, 8'h00);
    tick(1);
    chk("R8 irq released", {7'd0, irq_n}, 8'h01);

    // Pin 3 not enabled: flag sets but no summary, no irq
    pin_in[3] = 1'b1;
    tick(4);
    chk("R6 disabled pin no irq", {7'd0, irq_n}, 8'h01);
    rd(2'd2, v); chk("R6 disabled pin no summary", v, 8'h00);
    rd(2'd0, v); chk("R2 disabled pin flag", v, 8'h8C);

    // Writes to read-only addresses are ignored
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    rd(2'd0, v); chk("R9 change unaffected", v, 8'h0C);
    rd(2'd2, v); chk("R9 status unaffected", v, 8'h00);
    rd(2'd3, v); chk("R9 mask unaffected", v, 8'h80);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R5 enable upper bits zero", v, 8'h0F);

    // Two pins at once
    pin_in[1:0] = 2'b11;
    tick(3);
    rd(2'd0, v); chk("R2 two pins together", v, 8'h3F);
    rd(2'd0, v); chk("R3 both cleared", v, 8'h0F);

    // Vector table: mask and source combinations
    for (int k = 0; k < 8; k++) begin
      src_in = VEC[k][7:1];
      wr(2'd3, VEC[k][15:8]);
      tick(1);
      chk("R8 table irq_n", {7'd0, irq_n}, {7'd0, VEC[k][0]});
      rd(2'd2, v); chk("R6 table status", v, {1'b0, VEC[k][7:1]});
      rd(2'd3, v); chk("R7 table mask readback", v, VEC[k][15:8]);
    end

    // Source input latency: irq_n one edge after src rises
    wr(2'd3, 8'h08);
    src_in = 7'h00;
    tick(2);
    chk("R8 idle", {7'd0, irq_n}, 8'h01);
    src_in = 7'h08;
    #1 chk("R8 no same-cycle change", {7'd0, irq_n}, 8'h01);
    tick(1);
    chk("R8 one edge later", {7'd0, irq_n}, 8'h00);
    src_in = 7'h00;

    // Reset with pins held high: no flags
    pin_in = 4'hF;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(6);
    rd(2'd0, v); chk("R4 no flag from reset", v, 8'h0F);
    chk("R8 irq high after reset", {7'd0, irq_n}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule